// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block holds the working registers of a four-channel DMA controller. Each channel has a 16-bit transfer address and a 16-bit count word. A processor loads them through an 8-bit register port. When a transfer happens on a channel, the block shows that channel's current address and transfer type. It flags the end of the block and a periodic mark, and then advances the address and reduces the count.

Each count word has two parts. The low 14 bits hold the number of transfers minus one. The top two bits give the kind of transfer.

- A sticky status bit per channel records that the channel reached terminal count.
- An optional stop mode disables a channel once its block is done.
- An optional reload mode refills channel 2 from channel 3 in the cycle after channel 2 finishes. This lets two buffers be chained.

Arbitration between requesters, external address latching and memory strobes are handled elsewhere.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, all channel enables, the stop and reload options, all TC status bits and the update flag are clear. The status register reads 0x00 and transfer strobes have no effect.
- R2: The register port decodes as follows. When `reg_addr[3]` is 0, the access targets a channel register: `reg_addr[2:1]` picks the channel, and `reg_addr[0]` picks the address register (0) or the count register (1). `reg_addr` 8 is the mode register on write and the status register on read. A byte-pointer flip-flop selects the low byte (0) or the high byte (1) of a channel register. It toggles on every channel-register access, read or write, and a mode write clears it.
- R3: While `xfer_req` is high on an enabled channel, `cur_addr` shows that channel's address. At the clock edge the address then increments by one, modulo 2^16.
- R4: Each accepted transfer decrements the low 14 bits of the channel's count and leaves the top two bits unchanged; the 14-bit field wraps from 0 to 0x3FFF. `tc` is high on the transfer that finds the 14-bit field at zero. A loaded value N therefore gives TC on transfer N+1.
- R5: `xfer_type` shows bits [15:14] of the selected channel's count word. The encoding is 00 verify, 01 write to memory, 10 read from memory and 11 illegal.
- R6: `mark` is high on an accepted transfer whose count has its low 7 bits at zero. It therefore fires every 128 transfers, counted back from the end of the block.
- R7: Status bits [3:0] are the per-channel TC flags. A flag sets after its channel's TC transfer and stays set until the status register is read. If a new TC arrives in the same cycle as a status read, the flag stays set. Status bit 4 is the update flag.
- R8: The mode register uses bits [3:0] as channel enables, bit 4 as stop-at-TC and bit 5 as reload. A transfer on a disabled channel drives `tc` and `mark` low and leaves the channel's address and count unchanged.
- R9: With stop-at-TC set, a channel's enable bit clears after its TC transfer. The exception is channel 2 while reload is set.
- R10: With reload set, a TC on channel 2 raises the update flag for exactly the next cycle. In that cycle, channel 3's address and count are copied into channel 2, and transfers on channel 2 are ignored. Channel 3 itself does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_cs | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| xfer_req | input | 1 | Transfer strobe |
| xfer_ch | input | 2 | Channel being served |
| cur_addr | output | 16 | Address for the current transfer |
| xfer_type | output | 2 | Transfer type of the selected channel |
| tc | output | 1 | Terminal count on this transfer |
| mark | output | 1 | Modulo-128 mark on this transfer |

## Verification
The assertions check four relationships on every cycle:
- whenever `tc` is high, `mark` is high too;
- a TC always leaves its status flag set;
- with stop-at-TC set and no mode write in the same cycle, the enable bit clears after TC;
- a channel-2 TC with reload set is followed by an update flag that lasts exactly one cycle.

Some behaviour depends on long sequences and can only be shown by the bench's scenarios: address wrap, the positions of MARK across a 130-transfer block, count wrap after TC, byte-pointer sequencing and the contents of channel 2 after a reload. The bench reads these back through the register port.

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int AW = 16,
  parameter int CW = 14,
  parameter int MARK_BITS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_cs,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          xfer_req,
  input  logic [1:0]    xfer_ch,
  output logic [AW-1:0] cur_addr,
  output logic [1:0]    xfer_type,
  output logic          tc,
  output logic          mark
);
  localparam int WW = CW + 2;

  logic [AW-1:0] ch_addr [4];
  logic [WW-1:0] ch_cnt  [4];
  logic [5:0]    mode;
  logic [3:0]    tcst;
  logic          ff;
  logic          upd;

  logic creg, mode_wr, st_rd, go;
  logic [1:0] sel;
  logic [15:0] rsel;

  assign creg    = reg_cs && !reg_addr[3];
  assign sel     = reg_addr[2:1];
  assign mode_wr = reg_cs && reg_wr && reg_addr == 4'h8;
  assign st_rd   = reg_cs && !reg_wr && reg_addr == 4'h8;
  assign go      = xfer_req && mode[xfer_ch] && !(upd && xfer_ch == 2'd2);

  assign cur_addr  = ch_addr[xfer_ch];
  assign xfer_type = ch_cnt[xfer_ch][WW-1:WW-2];
  assign tc        = go && ch_cnt[xfer_ch][CW-1:0] == '0;
  assign mark      = go && ch_cnt[xfer_ch][MARK_BITS-1:0] == '0;

  assign rsel      = reg_addr[0] ? 16'(ch_cnt[sel]) : 16'(ch_addr[sel]);
  assign reg_rdata = reg_addr[3] ? {3'b0, upd, tcst} : (ff ? rsel[15:8] : rsel[7:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        ch_addr[c] <= '0;
        ch_cnt[c]  <= '0;
      end
      mode <= '0;
      tcst <= '0;
      ff   <= 1'b0;
      upd  <= 1'b0;
    end else begin
      for (int c = 0; c < 4; c++) begin
        if (upd && c == 2) begin
          ch_addr[c] <= ch_addr[3];
          ch_cnt[c]  <= ch_cnt[3];
        end else if (go && xfer_ch == 2'(c)) begin
          ch_addr[c]       <= ch_addr[c] + 1'b1;
          ch_cnt[c][CW-1:0] <= ch_cnt[c][CW-1:0] - 1'b1;
        end
        if (creg && reg_wr && sel == 2'(c)) begin
          if (reg_addr[0]) begin
            if (ff) ch_cnt[c][WW-1:8] <= reg_wdata[WW-9:0];
            else    ch_cnt[c][7:0]    <= reg_wdata;
          end else begin
            if (ff) ch_addr[c][AW-1:8] <= reg_wdata[AW-9:0];
            else    ch_addr[c][7:0]    <= reg_wdata;
          end
        end
      end

      if (mode_wr)
        mode <= reg_wdata[5:0];
      else if (tc && mode[4] && !(mode[5] && xfer_ch == 2'd2))
        mode[xfer_ch] <= 1'b0;

      if (mode_wr)   ff <= 1'b0;
      else if (creg) ff <= ~ff;

      tcst <= (st_rd ? 4'b0 : tcst) | (tc ? 4'(1) << xfer_ch : 4'b0);
      upd  <= tc && xfer_ch == 2'd2 && mode[5];
    end
  end
endmodule

module dma_xfer_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tc,
  input logic       mark,
  input logic [1:0] xfer_ch,
  input logic [5:0] mode,
  input logic [3:0] tcst,
  input logic       upd,
  input logic       mode_wr
);
  assert_tc_has_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> mark);
  assert_tc_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> tcst[$past(xfer_ch)]);
  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && mode[4] && !mode[5] && !mode_wr) |=> !mode[$past(xfer_ch)]);
  assert_upd_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && xfer_ch == 2'd2 && mode[5]) |=> upd);
  assert_upd_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);
endmodule

bind dma_xfer_engine dma_xfer_engine_chk u_chk (.*);

// File: tb/tb_dma_xfer_engine.sv
module tb_dma_xfer_engine;
  logic clk = 0, rst_n = 0;
  logic reg_cs = 0, reg_wr = 0, xfer_req = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [1:0] xfer_ch = 0, xfer_type;
  logic [15:0] cur_addr;
  logic tc, mark;
  int errs = 0, checks = 0;

  dma_xfer_engine dut (.*);

  always #10 clk = ~clk;

  initial begin
    #3_000_000;
    errs++; checks++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic chk(input string r, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", r, got, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [3:0] a, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    reg_cs = 1; reg_wr = w; reg_addr = a; reg_wdata = d;
    #2 q = reg_rdata;
    @(posedge clk); #1 reg_cs = 0;
  endtask

  task automatic wr8(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] q;
    acc(1, a, d, q);
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] d);
    wr8(a, d[7:0]); wr8(a, d[15:8]);
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    acc(0, a, 0, lo); acc(0, a, 0, hi);
    d = {hi, lo};
  endtask

  task automatic rdst(output logic [7:0] d);
    acc(0, 4'h8, 0, d);
  endtask

  task automatic xf(input logic [1:0] c, output logic t, output logic m,
                    output logic [15:0] a, output logic [1:0] ty);
    @(negedge clk);
    xfer_req = 1; xfer_ch = c;
    #2 t = tc; m = mark; a = cur_addr; ty = xfer_type;
    @(posedge clk); #1 xfer_req = 0;
  endtask

  initial begin
    logic [7:0] s;
    logic [15:0] v;
    logic t, m;
    logic [15:0] a;
    logic [1:0] ty;
    int nm;

    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rdst(s); chk("R1 status after reset", s, 0);
    xf(0, t, m, a, ty); chk("R1 transfer ignored after reset", {t, m}, 0);

    wr8(4'h8, 8'h11);
    wr16(4'h0, 16'h1234);
    wr16(4'h1, 16'h4003);
    for (int i = 0; i < 4; i++) begin
      xf(0, t, m, a, ty);
      chk("R3 address", a, 16'h1234 + i);
      chk("R5 type write", ty, 1);
      chk("R4 tc", t, i == 3);
      chk("R6 mark", m, i == 3);
    end
    xf(0, t, m, a, ty); chk("R9 stopped channel no tc", t, 0);
    rd16(4'h0, v); chk("R9 address frozen after stop", v, 16'h1238);
    rdst(s); chk("R7 tc flag set", s, 8'h01);
    rdst(s); chk("R7 tc flag cleared by read", s, 8'h00);

    wr8(4'h2, 8'hAA);
    wr8(4'h8, 8'h02);
    wr16(4'h2, 16'hFFFE);
    wr16(4'h3, 16'h0081);
    rd16(4'h2, v); chk("R2 mode write clears byte pointer", v, 16'hFFFE);
    rd16(4'h6, v); chk("R8 ch3 start addr", v, 0);
    nm = 0;
    for (int i = 0; i < 130; i++) begin
      xf(1, t, m, a, ty);
      if (a !== 16'((32'hFFFE + i) & 32'hFFFF)) chk("R3 wrap address", a, 16'((32'hFFFE + i) & 32'hFFFF));
      if (m) nm++;
      if (i == 1 || i == 129) chk("R6 mark position", m, 1);
      if (i == 129) chk("R4 tc at N+1", t, 1);
      else if (t) chk("R4 early tc", t, 0);
      if (i == 0) chk("R5 type verify", ty, 0);
    end
    chk("R6 mark count", nm, 2);
    rd16(4'h3, v); chk("R4 count wraps", v, 16'h3FFF);
    xf(3, t, m, a, ty); chk("R8 disabled channel", {t, m}, 0);
    rd16(4'h6, v); chk("R8 disabled address unchanged", v, 0);
    rdst(s); chk("R7 ch1 flag", s, 8'h02);

    wr8(4'h8, 8'h34);
    wr16(4'h4, 16'h0100);
    wr16(4'h5, 16'h4001);
    wr16(4'h6, 16'h4000);
    wr16(4'h7, 16'h8005);
    xf(2, t, m, a, ty); chk("R4 ch2 first", t, 0);
    xf(2, t, m, a, ty); chk("R4 ch2 tc", t, 1);
    rdst(s); chk("R10 update flag and tc flag", s, 8'h14);
    rdst(s); chk("R10 update flag one cycle", s, 8'h00);
    rd16(4'h4, v); chk("R10 ch2 address reloaded", v, 16'h4000);
    rd16(4'h5, v); chk("R10 ch2 count reloaded", v, 16'h8005);
    xf(2, t, m, a, ty);
    chk("R10 ch2 still enabled", a, 16'h4000);
    chk("R5 type read", ty, 2);
    rd16(4'h6, v); chk("R10 ch3 unchanged", v, 16'h4000);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule